// File: doc/BRIEF.md
# Per-Channel Test Tone Inserter

This block sits in the receive path of a 24-channel framed stream that feeds a parallel byte backplane. Each incoming byte carries a channel index, a valid strobe and a frame-start strobe. A per-channel bitmask picks which timeslots are overwritten. In a chosen timeslot, the received byte is replaced by one byte of a fixed eight-entry tone sequence. That sequence encodes a 1 kHz sine. Unselected timeslots pass through unchanged. The output is one register stage behind the input.

Software writes the mask through a byte-wide register port. The mask has three bytes, and each bit stands for one channel. Writes land in a shadow copy. The shadow copy is transferred to the working mask only at a frame start, so the selection never changes partway through a frame.

The position in the tone sequence is tracked by a two-state machine:
- **ST_WAIT_SYNC**: entered at reset. No frame start has been seen yet.
- **ST_RUN**: entered on the first accepted frame start.

The machine has three transitions:
- **T_SYNC** (ST_WAIT_SYNC to ST_RUN): the first frame start sets the phase to 0.
- **T_STEP** (ST_RUN to ST_RUN on a frame start): the phase advances by one and wraps after 7.
- **T_HOLD** (either state, no frame start): the state and the phase stay as they are.

All selected channels of one frame carry the same tone byte, so the tone repeats every 8 frames.

Top module: `chan_tone_inserter`

## Requirements
- R1: While `rst` is high at a clock edge, the block does the following. After that edge, `out_valid` is 0 and `out_data` is 0. The mask is cleared, and the machine returns to ST_WAIT_SYNC.
- R2: A byte whose channel mask bit is 0 appears unchanged on `out_data` one clock after it is presented. `out_valid` and `out_chan` carry the input's valid and channel index with the same one-clock delay.
- R3: A valid byte on a selected channel is replaced by the tone byte for the current phase. The tone bytes for phases 0 to 7 are 0x1E, 0x0B, 0x0B, 0x1E, 0x9E, 0x8B, 0x8B, 0x9E.
- R4: The register address selects a mask byte: address 0 covers channels 0 to 7, address 1 covers channels 8 to 15, and address 2 covers channels 16 to 23. Bit b of the byte at address a selects channel index 8a+b. Channel index 0 is the first channel of the frame and index 23 is the last. A write to address 3 has no effect.
- R5: A mask write takes effect at the next accepted frame start and never during the current frame. A write in the same cycle as a frame-start byte first applies at the following frame start.
- R6: The first accepted frame start after reset uses phase 0. Each later accepted frame start advances the phase by one, and the phase wraps from 7 to 0.
- R7: Before the first accepted frame start after reset, every byte passes unchanged, even if shadow mask bits are set.
- R8: A frame-start strobe is accepted only together with `in_valid`. A strobe without `in_valid` neither advances the phase nor loads the mask. Bytes with channel index 24 or above always pass unchanged.
- R9: A reset in mid-operation clears both the pending mask and the working mask and restarts the phase. The next frame therefore begins again at tone byte 0x1E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_fstart | input | 1 | Input byte is the first of a frame |
| in_chan | input | 5 | Channel index of the input byte (0 to 23) |
| in_data | input | 8 | Received byte |
| reg_wr | input | 1 | Mask register write strobe |
| reg_addr | input | 2 | Mask byte address (0 to 2; 3 ignored) |
| reg_wdata | input | 8 | Mask byte write data |
| out_valid | output | 1 | Output byte is valid |
| out_chan | output | 5 | Channel index of the output byte |
| out_data | output | 8 | Output byte, replaced or passed through |

## Verification
The bench drives a mask write in mid-frame and another in the same cycle as a frame-start byte. A design that applied writes at once would switch channels inside a frame, or would take up the new mask one frame early. The bench runs through more than eight frames with every channel selected. This catches a phase that fails to wrap, starts away from 0x1E, or steps on every byte instead of on every frame. The bench also sends frame-start strobes without valid, channel indices above 23, writes to the unused address, bytes before the first frame start, and a reset in mid-stream. A design that mishandled any of these would give the phase extra steps, overwrite bytes that should pass through, or keep a stale mask after reset.

// File: rtl/tone_pkg.sv
package tone_pkg;
    localparam int SEQ_LEN = 8;
    localparam int PHASE_W = $clog2(SEQ_LEN);

    typedef enum logic {
        ST_WAIT_SYNC = 1'b0,
        ST_RUN       = 1'b1
    } sync_state_t;

    function automatic logic [7:0] tone_byte(input logic [PHASE_W-1:0] ph);
        logic [7:0] v;
        unique case (ph)
            3'd0:    v = 8'h1E;
            3'd1:    v = 8'h0B;
            3'd2:    v = 8'h0B;
            3'd3:    v = 8'h1E;
            3'd4:    v = 8'h9E;
            3'd5:    v = 8'h8B;
            3'd6:    v = 8'h8B;
            default: v = 8'h9E;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/tone_phase_fsm.sv
module tone_phase_fsm
    import tone_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_go,
    output logic [PHASE_W-1:0] phase,
    output logic               synced
);
    sync_state_t        state_q, state_d;
    logic [PHASE_W-1:0] idx_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_SYNC;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (frame_go) idx_q <= phase;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        phase   = idx_q;
        unique case (state_q)
            ST_WAIT_SYNC: begin
                if (frame_go) begin        // T_SYNC
                    state_d = ST_RUN;
                    phase   = '0;
                end
            end
            ST_RUN: begin
                if (frame_go) begin        // T_STEP
                    phase = idx_q + 1'b1;
                end
            end
            default: state_d = ST_WAIT_SYNC;
        endcase
    end

    assign synced = (state_q == ST_RUN);

    p_phase_step_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_go && state_q == ST_RUN) |=> (idx_q == $past(idx_q) + 1'b1));

    p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_go |=> $stable(idx_q));

    p_first_phase_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_go && state_q == ST_WAIT_SYNC) |=> (idx_q == '0 && state_q == ST_RUN));
endmodule

// File: rtl/tone_mask_regs.sv
module tone_mask_regs #(
    parameter int NCH = 24,
    parameter int AW  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          load,
    output logic [NCH-1:0] eff_mask
);
    localparam int NREG = (NCH + 7) / 8;
    localparam int PADW = NREG * 8;

    logic [7:0]      shadow_q [NREG];
    logic [PADW-1:0] shadow_flat;
    logic [NCH-1:0]  active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) shadow_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++)
                if (wr_addr == AW'(i)) shadow_q[i] <= wr_data;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign shadow_flat[g*8 +: 8] = shadow_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst)       active_q <= '0;
        else if (load) active_q <= shadow_flat[NCH-1:0];
    end

    // On a frame-start byte the freshly loaded pending mask governs that frame.
    assign eff_mask = load ? shadow_flat[NCH-1:0] : active_q;

    p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active_q));

    p_addr_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= AW'(NREG)) |=> $stable(shadow_flat));
endmodule

// File: rtl/chan_tone_inserter.sv
module chan_tone_inserter
    import tone_pkg::*;
#(
    parameter  int NCH  = 24,
    localparam int CW   = $clog2(NCH),
    localparam int NREG = (NCH + 7) / 8,
    localparam int AW   = $clog2(NREG + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_fstart,
    input  logic [CW-1:0] in_chan,
    input  logic [7:0]    in_data,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic          out_valid,
    output logic [CW-1:0] out_chan,
    output logic [7:0]    out_data
);
    logic               frame_go;
    logic [PHASE_W-1:0] phase;
    logic               synced;
    logic [NCH-1:0]     eff_mask;
    logic               sel_bit;
    logic               hit;

    assign frame_go = in_valid && in_fstart;

    tone_phase_fsm u_phase (
        .clk      (clk),
        .rst      (rst),
        .frame_go (frame_go),
        .phase    (phase),
        .synced   (synced)
    );

    tone_mask_regs #(.NCH(NCH), .AW(AW)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .load     (frame_go),
        .eff_mask (eff_mask)
    );

    always_comb begin
        sel_bit = 1'b0;
        for (int i = 0; i < NCH; i++)
            if (in_chan == CW'(i)) sel_bit = eff_mask[i];
    end

    assign hit = in_valid && sel_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_chan  <= in_chan;
            out_data  <= hit ? tone_byte(phase) : in_data;
        end
    end

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_chan == $past(in_chan)));

    p_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hit) |=> (out_data == $past(in_data)));

    p_nosync_r7: assert property (@(posedge clk) disable iff (rst)
        (!synced && !frame_go) |=> (out_data == $past(in_data)));

    p_range_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'(in_chan) >= NCH) |=> (out_data == $past(in_data)));
endmodule

// File: tb/chan_tone_inserter_tb.sv
module chan_tone_inserter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_fstart, reg_wr;
    logic [4:0] in_chan;
    logic [7:0] in_data, reg_wdata;
    logic [1:0] reg_addr;
    logic       out_valid;
    logic [4:0] out_chan;
    logic [7:0] out_data;

    chan_tone_inserter dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fstart(in_fstart),
        .in_chan(in_chan), .in_data(in_data), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_tag = "R2";

    // reference model state
    byte unsigned tone_tab [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};
    bit pend [24];
    bit work [24];
    int phase_m = 0;
    bit sync_m = 0;

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit r, input bit v, input bit fs, input int ch, input int d,
                        input bit wr, input int wa, input int wd);
        int ev, ec, ed;
        bit rep;
        string tag;
        rst = r; in_valid = v; in_fstart = fs; in_chan = ch[4:0]; in_data = d[7:0];
        reg_wr = wr; reg_addr = wa[1:0]; reg_wdata = wd[7:0];
        rep = 0;
        if (r) begin
            ev = 0; ec = 0; ed = 0;
            foreach (pend[i]) begin pend[i] = 0; work[i] = 0; end
            phase_m = 0; sync_m = 0;
            tag = "R1";
        end else begin
            if (v && fs) begin
                foreach (pend[i]) work[i] = pend[i];
                phase_m = sync_m ? (phase_m + 1) % 8 : 0;
                sync_m = 1;
            end
            rep = v && sync_m && ch < 24 && work[ch < 24 ? ch : 0];
            ev = v; ec = ch; ed = rep ? tone_tab[phase_m] : d;
            if (wr && wa < 3)
                for (int b = 0; b < 8; b++) pend[wa*8+b] = wd[b];
            tag = rep ? "R3" : cur_tag;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, out_valid, ev, "out_valid");
        if (r) check(tag, out_data, 0, "out_data at reset");
        if (ev != 0) begin
            check(tag, out_chan, ec, "out_chan");
            check(tag, out_data, ed, "out_data");
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h55, 0, 0, 0);
    endtask

    // one frame; optional register write at byte wr_at; optional gaps
    task automatic frame(input int wr_at, input int wa, input int wd, input bit gaps);
        for (int c = 0; c < 24; c++) begin
            step(0, 1, c == 0, c, $urandom_range(0, 255), c == wr_at, wa, wd);
            if (gaps) step(0, 0, 1, 0, 8'hAA, 0, 0, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) step(1, 1, 1, 3, 8'hFF, 1, 0, 8'hFF);
        // R7: mask set, but no frame start yet
        cur_tag = "R7";
        step(0, 0, 0, 0, 0, 1, 0, 8'hFF);
        step(0, 0, 0, 0, 0, 1, 1, 8'hFF);
        step(0, 0, 0, 0, 0, 1, 2, 8'hFF);
        for (int c = 0; c < 24; c++) step(0, 1, 0, c, c * 7, 0, 0, 0);
        // R6: all channels replaced, phase wraps over 10 frames
        cur_tag = "R6";
        for (int f = 0; f < 10; f++) frame(-1, 0, 0, 0);
        // R4: per-byte mapping
        cur_tag = "R4";
        step(0, 0, 0, 0, 0, 1, 0, 8'h81);
        step(0, 0, 0, 0, 0, 1, 1, 8'h00);
        step(0, 0, 0, 0, 0, 1, 2, 8'h5A);
        frame(-1, 0, 0, 0);
        frame(-1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 3, 8'hFF);   // ignored address
        frame(-1, 0, 0, 0);
        // R5: mid-frame write, and write on the frame-start byte
        cur_tag = "R5";
        frame(11, 1, 8'hF0, 0);
        frame(0, 0, 8'h00, 0);
        frame(-1, 0, 0, 0);
        // R8: strobes without valid, channels above 23
        cur_tag = "R8";
        frame(-1, 0, 0, 1);
        for (int c = 24; c < 32; c++) step(0, 1, 0, c, 8'h3C, 0, 0, 0);
        step(0, 1, 1, 27, 8'h11, 0, 0, 0);
        frame(-1, 0, 0, 0);
        // R2: mask cleared, pure pass-through
        cur_tag = "R2";
        step(0, 0, 0, 0, 0, 1, 0, 8'h00);
        step(0, 0, 0, 0, 0, 1, 1, 8'h00);
        step(0, 0, 0, 0, 0, 1, 2, 8'h00);
        frame(-1, 0, 0, 0);
        frame(-1, 0, 0, 1);
        // R9: reset in mid-operation
        cur_tag = "R9";
        step(0, 0, 0, 0, 0, 1, 1, 8'hFF);
        frame(-1, 0, 0, 0);
        for (int c = 0; c < 5; c++) step(0, 1, c == 0, c, 8'h42, 0, 0, 0);
        step(1, 1, 0, 5, 8'h42, 0, 0, 0);
        frame(-1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 2, 8'h0F);
        frame(-1, 0, 0, 0);
        frame(-1, 0, 0, 0);
        idle(3);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule